// File: doc/BRIEF.md
# Prescaled Compare Timer with Register Interface

This peripheral keeps an up-counter that steps on a divided clock and returns to zero after it reaches a programmable limit. One compare channel watches the count and sets a sticky flag when the count lands on a programmed value. The flag can drive an interrupt line. Software reaches everything through a 32-bit register port. The read-only width field lets a driver find out how wide the counter is. A driver typically picks a divide ratio and starts the counter. For each timeout it writes a compare value equal to the current count plus a delta. It then clears the flag when the interrupt arrives.

Reads are combinational from the selected address. Writes take effect at the clock edge. The counter width is a parameter. The count, the limit and the compare value occupy only the low bits of their registers.

Top module: `cmp_tick_timer`

## Requirements
- R1: Offset 0x04 returns the counter width in bits in bits 23:16 (0x10 for a 16-bit counter, 0x20 for a 32-bit counter). All other bits of this register read zero, and writes to it change nothing.
- R2: Offset 0x10 holds the divide select in bits 2:0 and the run enable in bit 3. Both are writable and read back, and both reset to zero.
- R3: While the run enable is 1, the count advances once every 2^select clock cycles. While the run enable is 0, the count holds.
- R4: A write of any value to offset 0x14 sets the count to zero at that edge and restarts the divider phase. Reads of 0x14 return the count.
- R5: Offset 0x18 holds the limit, which resets to all ones. A step taken while the count equals the limit makes the count zero.
- R6: Bit 7 of offset 0x10 is the overflow flag. It is set by a step from the limit back to zero, and it is cleared by writing 1 to it. If a set and a clear fall on the same edge, the flag is set.
- R7: Offset 0x20 holds the channel mode in bits 5:2 and the interrupt enable in bit 6. Bit 7 of offset 0x20 shows the match flag, and writing 1 to that bit clears the flag.
- R8: When the channel mode is 0x4, a step that brings the count to the value held at offset 0x24 sets the match flag.
- R9: Bit 0 of offset 0x1C shows the same match flag. Writing 1 to that bit also clears it.
- R10: The interrupt output is high exactly while the match flag and the interrupt enable are both 1.
- R11: While the channel mode is anything other than 0x4, the match flag is never newly set.
- R12: If a match and a clear of the match flag fall on the same edge, the flag stays set.
- R13: Register bits not listed above read zero and ignore writes. Unmapped offsets read zero. The count, the limit and the compare value keep only the low counter-width bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access select |
| busWrite | input | 1 | 1 makes the selected access a write |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the selected offset, zero when busSel is low |
| irqOut | output | 1 | Channel interrupt |
| ovfFlag | output | 1 | Overflow flag |
| matchFlag | output | 1 | Channel match flag |

## Verification
The assertions check the following on every cycle:
- a write to the count register zeroes the count;
- a stopped counter holds its value;
- a step at the limit lands on zero;
- the overflow flag rises only after a step at the limit;
- the match flag stays set unless a clear is requested;
- the match flag never rises while the channel mode is off;
- the interrupt is never high without the flag.

Some behaviours can only be shown by the bench's scenarios, where a behavioural model is compared against every output and the read data on each clock. These are:
- the exact stepping rate for each divide select;
- the match against the programmed value;
- clearing the same flag through either of its two locations;
- set winning over a coincident clear;
- truncation of wide writes;
- zero reads of unlisted bits.

// File: rtl/cmp_tick_timer_pkg.sv
`timescale 1ns/1ps
package cmp_tick_timer_pkg;
  // register offsets; drivers depend on these positions
  localparam int OFS_PARAM    = 'h04;
  localparam int OFS_CTRL     = 'h10;
  localparam int OFS_COUNT    = 'h14;
  localparam int OFS_MODULO   = 'h18;
  localparam int OFS_STATUS   = 'h1C;
  localparam int OFS_CH_CTRL  = 'h20;
  localparam int OFS_CH_VALUE = 'h24;

  localparam int              PS_W          = 3;
  localparam int              DIV_W         = (1 << PS_W) - 1;
  localparam logic [3:0]      CH_MODE_SWCMP = 4'h4;

  // one-cycle strobes from register decode to the counting datapath
  typedef struct packed {
    logic countClr;
    logic ovfClr;
    logic matchClr;
  } strobe_t;
endpackage

// File: rtl/cmp_tick_timer_ctrl.sv
`timescale 1ns/1ps
module cmp_tick_timer_ctrl
  import cmp_tick_timer_pkg::*;
#(
  parameter int CW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CW-1:0]     cntVal,
  input  logic              ovfState,
  input  logic              matchState,
  output strobe_t           strb,
  output logic [PS_W-1:0]   psSel,
  output logic              clkEn,
  output logic [CW-1:0]     modVal,
  output logic [3:0]        chMode,
  output logic              chIe,
  output logic [CW-1:0]     cmpVal
);
  localparam logic [7:0] WIDTH_CODE = 8'(CW);

  logic wrEn;
  logic hitParam, hitCtrl, hitCount, hitModulo, hitStatus, hitChCtrl, hitChValue;

  assign wrEn       = busSel && busWrite;
  assign hitParam   = busAddr == ADDR_W'(OFS_PARAM);
  assign hitCtrl    = busAddr == ADDR_W'(OFS_CTRL);
  assign hitCount   = busAddr == ADDR_W'(OFS_COUNT);
  assign hitModulo  = busAddr == ADDR_W'(OFS_MODULO);
  assign hitStatus  = busAddr == ADDR_W'(OFS_STATUS);
  assign hitChCtrl  = busAddr == ADDR_W'(OFS_CH_CTRL);
  assign hitChValue = busAddr == ADDR_W'(OFS_CH_VALUE);

  always_comb begin
    strb.countClr = wrEn && hitCount;
    strb.ovfClr   = wrEn && hitCtrl && busWdata[7];
    strb.matchClr = wrEn && ((hitStatus && busWdata[0]) || (hitChCtrl && busWdata[7]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psSel  <= '0;
      clkEn  <= 1'b0;
      modVal <= '1;
      chMode <= '0;
      chIe   <= 1'b0;
      cmpVal <= '0;
    end else if (wrEn) begin
      if (hitCtrl) begin
        psSel <= busWdata[PS_W-1:0];
        clkEn <= busWdata[3];
      end
      if (hitModulo)  modVal <= busWdata[CW-1:0];
      if (hitChCtrl) begin
        chMode <= busWdata[5:2];
        chIe   <= busWdata[6];
      end
      if (hitChValue) cmpVal <= busWdata[CW-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      if (hitParam)   busRdata[23:16] = WIDTH_CODE;
      if (hitCtrl)    busRdata[7:0]   = {ovfState, 3'b000, clkEn, psSel};
      if (hitCount)   busRdata[CW-1:0] = cntVal;
      if (hitModulo)  busRdata[CW-1:0] = modVal;
      if (hitStatus)  busRdata[0]     = matchState;
      if (hitChCtrl)  busRdata[7:0]   = {matchState, chIe, chMode, 2'b00};
      if (hitChValue) busRdata[CW-1:0] = cmpVal;
    end
  end
endmodule

// File: rtl/cmp_tick_timer_dp.sv
`timescale 1ns/1ps
module cmp_tick_timer_dp
  import cmp_tick_timer_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PS_W-1:0] psSel,
  input  logic            clkEn,
  input  logic [CW-1:0]   modVal,
  input  logic [3:0]      chMode,
  input  logic [CW-1:0]   cmpVal,
  output logic [CW-1:0]   cntVal,
  output logic            ovfState,
  output logic            matchState,
  output logic            tick
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [CW-1:0]    cntNext;
  logic             atLimit, wrapEv, matchEv;

  // low psSel bits of the free divider must all be ones for a tick
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign divMask[i] = i < int'(psSel);
  end

  assign tick    = clkEn && ((divCnt & divMask) == divMask);
  assign atLimit = cntVal == modVal;
  assign cntNext = atLimit ? '0 : cntVal + 1'b1;
  assign wrapEv  = tick && atLimit && !strb.countClr;
  assign matchEv = tick && !strb.countClr && (chMode == CH_MODE_SWCMP) && (cntNext == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      cntVal     <= '0;
      ovfState   <= 1'b0;
      matchState <= 1'b0;
    end else begin
      divCnt <= (!clkEn || strb.countClr) ? '0 : divCnt + 1'b1;
      if (strb.countClr)  cntVal <= '0;
      else if (tick)      cntVal <= cntNext;
      if (wrapEv)         ovfState <= 1'b1;
      else if (strb.ovfClr) ovfState <= 1'b0;
      if (matchEv)        matchState <= 1'b1;
      else if (strb.matchClr) matchState <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_tick_timer.sv
`timescale 1ns/1ps
module cmp_tick_timer
  import cmp_tick_timer_pkg::*;
#(
  parameter int CW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              ovfFlag,
  output logic              matchFlag
);
  strobe_t         strb;
  logic [PS_W-1:0] psSel;
  logic            clkEn, chIe, tick, ovfState, matchState;
  logic [CW-1:0]   modVal, cmpVal, cntVal;
  logic [3:0]      chMode;

  cmp_tick_timer_ctrl #(.CW(CW), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .ovfState(ovfState), .matchState(matchState),
    .strb(strb), .psSel(psSel), .clkEn(clkEn), .modVal(modVal),
    .chMode(chMode), .chIe(chIe), .cmpVal(cmpVal)
  );

  cmp_tick_timer_dp #(.CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .psSel(psSel), .clkEn(clkEn),
    .modVal(modVal), .chMode(chMode), .cmpVal(cmpVal), .cntVal(cntVal),
    .ovfState(ovfState), .matchState(matchState), .tick(tick)
  );

  assign ovfFlag   = ovfState;
  assign matchFlag = matchState;
  assign irqOut    = matchState && chIe;
endmodule

// File: rtl/cmp_tick_timer_chk.sv
`timescale 1ns/1ps
module cmp_tick_timer_chk
  import cmp_tick_timer_pkg::*;
#(
  parameter int CW     = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CW-1:0]     cntVal,
  input logic [CW-1:0]     modVal,
  input logic              tick,
  input logic              clkEn,
  input logic [3:0]        chMode,
  input logic              matchClr,
  input logic              ovfFlag,
  input logic              matchFlag,
  input logic              irqOut
);
  logic countWr;
  assign countWr = busSel && busWrite && (busAddr == ADDR_W'(OFS_COUNT));

  a_r4_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    countWr |=> (cntVal == '0));

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !countWr) |=> $stable(cntVal));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (cntVal == modVal) && !countWr) |=> (cntVal == '0));

  a_r6_ovf_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(tick && (cntVal == modVal)));

  a_r11_no_match_when_off: assert property (@(posedge clk) disable iff (!rstN)
    ((chMode != CH_MODE_SWCMP) && !matchFlag) |=> !matchFlag);

  a_r12_match_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !matchClr) |=> matchFlag);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> matchFlag);
endmodule

bind cmp_tick_timer cmp_tick_timer_chk #(.CW(CW), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .cntVal(cntVal), .modVal(modVal), .tick(tick),
  .clkEn(clkEn), .chMode(chMode), .matchClr(strb.matchClr),
  .ovfFlag(ovfFlag), .matchFlag(matchFlag), .irqOut(irqOut)
);

// File: tb/cmp_tick_timer_bench.sv
`timescale 1ns/1ps
module cmp_tick_timer_bench;
  localparam int          CW   = 16;
  localparam int unsigned MASK = (1 << CW) - 1;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWrite = 0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, ovfFlag, matchFlag;

  int testCount = 0, failCount = 0;
  logic [7:0] watchAddr = 8'h14;
  bit running = 0, finished = 0;

  cmp_tick_timer #(.CW(CW), .ADDR_W(8)) u_cmp_tick_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .ovfFlag(ovfFlag), .matchFlag(matchFlag)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int unsigned mPs, mPhase, mCnt, mMod, mCv, mChMode, lim;
  bit mEn, mIe, mTof, mChf, tk, wr, clrC, hit, wrapEv, clrTof, clrChf;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPs = 0; mEn = 0; mPhase = 0; mCnt = 0; mMod = MASK; mCv = 0;
      mChMode = 0; mIe = 0; mTof = 0; mChf = 0;
    end else begin
      lim    = (1 << mPs) - 1;
      tk     = mEn && ((mPhase % (lim + 1)) == lim);
      wr     = busSel && busWrite;
      clrC   = wr && busAddr == 8'h14;
      clrTof = wr && busAddr == 8'h10 && busWdata[7];
      clrChf = wr && ((busAddr == 8'h1C && busWdata[0]) || (busAddr == 8'h20 && busWdata[7]));
      hit = 0; wrapEv = 0;
      if (clrC) mCnt = 0;
      else if (tk) begin
        if (mCnt == mMod) begin mCnt = 0; wrapEv = 1; end
        else mCnt = (mCnt + 1) & MASK;
        hit = (mChMode == 4) && (mCnt == mCv);
      end
      mPhase = (!mEn || clrC) ? 0 : (mPhase + 1) % 128;
      if (wrapEv) mTof = 1; else if (clrTof) mTof = 0;
      if (hit) mChf = 1; else if (clrChf) mChf = 0;
      if (wr) begin
        case (busAddr)
          8'h10: begin mPs = busWdata[2:0]; mEn = busWdata[3]; end
          8'h18: mMod = busWdata & MASK;
          8'h20: begin mChMode = busWdata[5:2]; mIe = busWdata[6]; end
          8'h24: mCv = busWdata & MASK;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h04: return 32'(CW) << 16;
      8'h10: return {24'd0, mTof, 3'd0, mEn, 3'(mPs)};
      8'h14: return mCnt;
      8'h18: return mMod;
      8'h1C: return {31'd0, mChf};
      8'h20: return {24'd0, mChf, mIe, 4'(mChMode), 2'd0};
      8'h24: return mCv;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    case (a)
      8'h04: return "R1";
      8'h10: return "R2";
      8'h14: return "R3";
      8'h18: return "R5";
      8'h1C: return "R9";
      8'h20: return "R7";
      8'h24: return "R13";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN && running && !finished) begin
      check(reqOf(busAddr), busRdata, modelRead(busAddr));
      check("R6 ovf", {31'd0, ovfFlag}, {31'd0, mTof});
      check("R8 R12 match", {31'd0, matchFlag}, {31'd0, mChf});
      check("R10 irq", {31'd0, irqOut}, {31'd0, mChf && mIe});
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1;
    @(negedge clk);
    busWrite = 0; busAddr = watchAddr;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; #1;
    check(tag, busRdata, exp);
    busAddr = watchAddr;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    busSel = 1; busAddr = watchAddr;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    rdChk(8'h04, 32'h0010_0000, "R1 width field");
    rdChk(8'h10, 32'h0, "R2 ctrl reset");
    rdChk(8'h14, 32'h0, "R3 count reset");
    rdChk(8'h18, 32'h0000_FFFF, "R5 limit reset");
    rdChk(8'h3C, 32'h0, "R13 unmapped");
    running = 1;
    // read-only and truncation
    wrReg(8'h04, 32'hFFFF_FFFF);
    rdChk(8'h04, 32'h0010_0000, "R1 read-only");
    wrReg(8'h18, 32'h0001_2345);
    rdChk(8'h18, 32'h0000_2345, "R13 limit truncated");
    wrReg(8'h10, 32'hFFFF_FF77);
    rdChk(8'h10, 32'h0000_0007, "R2 R13 ctrl bits");
    wrReg(8'h10, 32'h0);
    // run with divide 1, limit 9, compare 4
    wrReg(8'h18, 9);
    wrReg(8'h24, 4);
    wrReg(8'h20, 32'h0000_0050);
    wrReg(8'h14, 0);
    wrReg(8'h10, 32'h0000_0008);
    idle(25);
    check("R6 ovf seen", {31'd0, ovfFlag}, 32'd1);
    check("R8 match seen", {31'd0, matchFlag}, 32'd1);
    check("R10 irq seen", {31'd0, irqOut}, 32'd1);
    // clear via global status, then via channel control
    wrReg(8'h10, 32'h0000_0088);
    wrReg(8'h1C, 1);
    idle(3);
    wrReg(8'h20, 32'h0000_00D0);
    idle(3);
    // clear hammering across a match edge: set must win
    watchAddr = 8'h1C;
    for (int i = 0; i < 24; i++) wrReg(8'h1C, 1);
    watchAddr = 8'h14;
    // divide by 8
    wrReg(8'h10, 32'h0000_000B);
    idle(200);
    // divide by 128, limit 1
    wrReg(8'h18, 1);
    wrReg(8'h10, 32'h0000_000F);
    idle(600);
    // stop counting, count write zeroes
    wrReg(8'h10, 0);
    idle(5);
    wrReg(8'h14, 32'hDEAD_BEEF);
    rdChk(8'h14, 32'h0, "R4 count cleared");
    idle(5);
    rdChk(8'h14, 32'h0, "R3 stopped holds");
    // channel off modes: no new flags
    wrReg(8'h20, 32'h0000_00D4);
    wrReg(8'h18, 9);
    wrReg(8'h10, 32'h0000_0008);
    idle(40);
    check("R11 mode 5 no match", {31'd0, matchFlag}, 32'd0);
    wrReg(8'h20, 32'h0000_0040);
    idle(40);
    check("R11 mode 0 no match", {31'd0, matchFlag}, 32'd0);
    // re-enable compare, interrupt masked
    wrReg(8'h20, 32'h0000_0010);
    watchAddr = 8'h20;
    idle(30);
    check("R10 masked irq", {31'd0, irqOut}, 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      testCount++; failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule